// File: doc/BRIEF.md
# Staged memory fill engine

This block fills a region of memory with one repeated byte value. Software-visible state is held outside the block, as a destination-address value, a byte-count value and a four-bit condition-flag value (N, Z, C, V in bits 3 down to 0). The fill runs as three commands issued one after another: a prologue, a main pass and an epilogue. Each command is launched with a single-cycle `start` pulse. The block raises `busy` while it works and pulses `done` for one cycle when it finishes. While `done` is high it presents the updated address and count values. When the command was a prologue it also presents new flags, qualified by `flags_we`.

Two counting conventions are supported. In the end-relative convention the address points one past the region and the count is a negative offset from it. In the forward convention the address advances and the count is a positive remaining length. The prologue preconditions the operands for the chosen convention and records the choice in the carry flag. The later stages read the carry back through `carry_in` to select the same convention. Writes go out as block requests of up to 16 bytes on a valid/ready memory port. The port answers with the number of bytes it actually wrote and a fault flag. A short grant or a fault stops the command, and only completed chunks are reflected in the results.

The controller has three states. S_IDLE waits for `start`. S_WORK issues chunk requests. S_DONE presents results for one cycle. The transitions are as follows:
- S_IDLE to S_DONE on a prologue or an illegal stage code.
- S_IDLE to S_WORK on a main or epilogue command.
- S_WORK to S_WORK after each fully granted chunk.
- S_WORK to S_DONE when no chunk remains for the stage, or when a request is short-granted or faults.
- S_DONE to S_IDLE always.

Top module: `fill_engine`

## Requirements
- R1: Every memory request carries, on `mem_byte`, the `fill_byte` value captured at `start`.
- R2: Stage code 2'b11 is illegal. The block pulses `done` with `illegal`=1 and issues no memory request. It returns the input address and count unchanged and keeps `flags_we` at 0.
- R3: The prologue reads `count_in` as unsigned and clamps any value above 0x7FFF_FFFF_FFFF_FFFF to that value before preconditioning.
- R4: A prologue with `prologue_fwd`=0 returns address+count and the two's-complement negation of the count. It writes flags 4'b0000, and issues no memory request.
- R5: A prologue with `prologue_fwd`=1 returns the address and (clamped) count unchanged. It writes flags 4'b0010 (carry set), and issues no memory request.
- R6: With `carry_in`=0 (end-relative), each chunk of B bytes is requested at address+count. The count then rises by B and the address is unchanged. Work continues only while the count is negative.
- R7: With `carry_in`=1 (forward), each chunk of B bytes is requested at the current address. The address then rises by B and the count falls by B. Work continues only while the count is positive.
- R8: The main stage issues only full 16-byte chunks and stops once fewer than 16 bytes remain. The epilogue issues 16-byte chunks, then 1-byte requests, until the count reaches zero. The bytes written are contiguous with no overlap.
- R9: A grant smaller than the requested length, or `mem_fault`=1, ends the command with `fault`=1. No further request is issued, and the results reflect only the chunks completed before it.
- R10: `flags_we` is 1 only on the `done` cycle of a prologue.
- R11: A pending request holds its address and length stable until `mem_ready`. `done` lasts exactly one cycle.
- R12: The main and epilogue stages take their convention from `carry_in`, and ignore `prologue_fwd`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a command (sampled in S_IDLE) |
| stage | input | 2 | 00 prologue, 01 main, 10 epilogue, 11 illegal |
| prologue_fwd | input | 1 | Convention chosen by a prologue: 1 forward, 0 end-relative |
| carry_in | input | 1 | Carry flag from the prologue, selects convention for main/epilogue |
| addr_in | input | 64 | Destination-address operand |
| count_in | input | 64 | Byte-count operand |
| fill_byte | input | 8 | Fill value (low byte of the source operand) |
| busy | output | 1 | Command in progress (S_WORK) |
| done | output | 1 | One-cycle completion pulse (S_DONE) |
| illegal | output | 1 | Last command had an illegal stage code |
| fault | output | 1 | Last command stopped on a memory fault |
| addr_out | output | 64 | Updated address value |
| count_out | output | 64 | Updated count value |
| flags_out | output | 4 | New NZCV value |
| flags_we | output | 1 | flags_out is to be written |
| mem_valid | output | 1 | Write request valid |
| mem_addr | output | 64 | Request start address |
| mem_len | output | 5 | Request length in bytes (1..16) |
| mem_byte | output | 8 | Byte to write |
| mem_ready | input | 1 | Request accepted and answered this cycle |
| mem_granted | input | 5 | Bytes actually written |
| mem_fault | input | 1 | Write faulted |

## Verification
The fill is run as two full prologue, main and epilogue sequences, one end-relative and one forward. Each uses a length that leaves a tail, so chunk and byte requests and the hand-over between stages can all be seen. Clamped counts at the top of the unsigned range separate the unsigned prologue reading from the signed reading of the later stages. Short main counts, a mid-stream short grant and an epilogue that faults on its first byte separate "no work" from "stopped on fault". A memory model that stalls some requests tests the request-hold rule. Address span against byte total catches gaps or overlaps, and per-request byte comparison catches a wrong fill value.

// File: rtl/fill_pkg.sv
package fill_pkg;

    typedef enum logic [1:0] {
        STG_PRO  = 2'b00,
        STG_MAIN = 2'b01,
        STG_EPI  = 2'b10,
        STG_BAD  = 2'b11
    } stage_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WORK = 2'd1,
        S_DONE = 2'd2
    } state_e;

    localparam logic [3:0] FLAGS_END = 4'b0000;
    localparam logic [3:0] FLAGS_FWD = 4'b0010;

endpackage

// File: rtl/fill_precond.sv
module fill_precond #(
    parameter int AW = 64
) (
    input  logic          fwd,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] cnt,
    output logic [AW-1:0] addr_o,
    output logic [AW-1:0] cnt_o,
    output logic [3:0]    flags_o
);
    import fill_pkg::*;

    localparam logic [AW-1:0] CLAMP_MAX = {1'b0, {(AW-1){1'b1}}};

    logic [AW-1:0] clamped;

    always_comb begin
        clamped = cnt[AW-1] ? CLAMP_MAX : cnt;
        if (fwd) begin
            addr_o  = addr;
            cnt_o   = clamped;
            flags_o = FLAGS_FWD;
        end else begin
            addr_o  = addr + clamped;
            cnt_o   = ~clamped + 1'b1;
            flags_o = FLAGS_END;
        end
    end

endmodule

// File: rtl/fill_chunk_sel.sv
module fill_chunk_sel #(
    parameter int AW    = 64,
    parameter int CHUNK = 16,
    parameter int LENW  = $clog2(CHUNK) + 1
) (
    input  logic            fwd,
    input  logic            epi,
    input  logic [AW-1:0]   addr,
    input  logic [AW-1:0]   cnt,
    output logic            more,
    output logic [AW-1:0]   req_addr,
    output logic [LENW-1:0] req_len
);
    localparam logic [AW-1:0]   CHUNK_W = AW'(CHUNK);
    localparam logic [LENW-1:0] CHUNK_L = LENW'(CHUNK);

    logic [AW-1:0] mag;
    logic          pending;
    logic          big;

    always_comb begin
        mag      = fwd ? cnt : (~cnt + 1'b1);
        pending  = fwd ? ($signed(cnt) > 0) : cnt[AW-1];
        big      = (mag >= CHUNK_W);
        req_len  = big ? CHUNK_L : (epi ? LENW'(1) : '0);
        more     = pending && (big || epi);
        req_addr = fwd ? addr : (addr + cnt);
    end

endmodule

// File: rtl/fill_engine.sv
module fill_engine #(
    parameter int AW    = 64,
    parameter int CHUNK = 16,
    parameter int LENW  = $clog2(CHUNK) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      stage,
    input  logic            prologue_fwd,
    input  logic            carry_in,
    input  logic [AW-1:0]   addr_in,
    input  logic [AW-1:0]   count_in,
    input  logic [7:0]      fill_byte,
    output logic            busy,
    output logic            done,
    output logic            illegal,
    output logic            fault,
    output logic [AW-1:0]   addr_out,
    output logic [AW-1:0]   count_out,
    output logic [3:0]      flags_out,
    output logic            flags_we,
    output logic            mem_valid,
    output logic [AW-1:0]   mem_addr,
    output logic [LENW-1:0] mem_len,
    output logic [7:0]      mem_byte,
    input  logic            mem_ready,
    input  logic [LENW-1:0] mem_granted,
    input  logic            mem_fault
);
    import fill_pkg::*;

    state_e        state;
    logic [AW-1:0] r_addr;
    logic [AW-1:0] r_cnt;
    logic          r_fwd;
    logic          r_epi;
    logic [7:0]    r_byte;
    logic [3:0]    r_flags;
    logic          r_fwe;
    logic          r_ill;
    logic          r_flt;

    logic [AW-1:0]   pre_addr;
    logic [AW-1:0]   pre_cnt;
    logic [3:0]      pre_flags;
    logic            more;
    logic [AW-1:0]   req_addr;
    logic [LENW-1:0] req_len;
    logic [AW-1:0]   len_w;
    logic            full_grant;

    fill_precond #(.AW(AW)) u_pre (
        .fwd     (prologue_fwd),
        .addr    (addr_in),
        .cnt     (count_in),
        .addr_o  (pre_addr),
        .cnt_o   (pre_cnt),
        .flags_o (pre_flags)
    );

    fill_chunk_sel #(.AW(AW), .CHUNK(CHUNK), .LENW(LENW)) u_sel (
        .fwd      (r_fwd),
        .epi      (r_epi),
        .addr     (r_addr),
        .cnt      (r_cnt),
        .more     (more),
        .req_addr (req_addr),
        .req_len  (req_len)
    );

    assign len_w      = {{(AW-LENW){1'b0}}, req_len};
    assign full_grant = (mem_granted == req_len) && !mem_fault;

    // State register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            r_addr  <= '0;
            r_cnt   <= '0;
            r_fwd   <= 1'b0;
            r_epi   <= 1'b0;
            r_byte  <= '0;
            r_flags <= '0;
            r_fwe   <= 1'b0;
            r_ill   <= 1'b0;
            r_flt   <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        r_fwe  <= 1'b0;
                        r_ill  <= 1'b0;
                        r_flt  <= 1'b0;
                        r_byte <= fill_byte;
                        unique case (stage_e'(stage))
                            STG_PRO: begin
                                r_addr  <= pre_addr;
                                r_cnt   <= pre_cnt;
                                r_flags <= pre_flags;
                                r_fwe   <= 1'b1;
                                state   <= S_DONE;
                            end
                            STG_MAIN, STG_EPI: begin
                                r_addr <= addr_in;
                                r_cnt  <= count_in;
                                r_fwd  <= carry_in;
                                r_epi  <= (stage_e'(stage) == STG_EPI);
                                state  <= S_WORK;
                            end
                            STG_BAD: begin
                                r_addr <= addr_in;
                                r_cnt  <= count_in;
                                r_ill  <= 1'b1;
                                state  <= S_DONE;
                            end
                        endcase
                    end
                end
                S_WORK: begin
                    if (!more) begin
                        state <= S_DONE;
                    end else if (mem_ready) begin
                        if (full_grant) begin
                            if (r_fwd) begin
                                r_addr <= r_addr + len_w;
                                r_cnt  <= r_cnt - len_w;
                            end else begin
                                r_cnt  <= r_cnt + len_w;
                            end
                        end else begin
                            r_flt <= 1'b1;
                            state <= S_DONE;
                        end
                    end
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (state == S_WORK);
        done      = (state == S_DONE);
        mem_valid = (state == S_WORK) && more;
        mem_addr  = req_addr;
        mem_len   = req_len;
        mem_byte  = r_byte;
        addr_out  = r_addr;
        count_out = r_cnt;
        flags_out = r_flags;
        flags_we  = r_fwe && (state == S_DONE);
        illegal   = r_ill;
        fault     = r_flt;
    end

endmodule

// File: rtl/fill_engine_chk.sv
module fill_engine_chk #(
    parameter int AW    = 64,
    parameter int CHUNK = 16,
    parameter int LENW  = $clog2(CHUNK) + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            done,
    input logic            illegal,
    input logic            fault,
    input logic            flags_we,
    input logic [AW-1:0]   count_out,
    input logic            mem_valid,
    input logic [AW-1:0]   mem_addr,
    input logic [LENW-1:0] mem_len,
    input logic            mem_ready,
    input logic [LENW-1:0] mem_granted,
    input logic            mem_fault
);
    // R8
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_len != '0) && (mem_len <= LENW'(CHUNK)));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_len)));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    flags_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flags_we |-> (done && !illegal && !fault));

    // R9
    fault_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && ((mem_granted != mem_len) || mem_fault)) |=> (done && fault && !mem_valid));

    // R6
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_ready && (mem_granted == mem_len) && !mem_fault) |=> (count_out != $past(count_out)));

    // R2
    illegal_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (!fault && !flags_we));

endmodule

bind fill_engine fill_engine_chk #(.AW(AW), .CHUNK(CHUNK), .LENW(LENW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .illegal     (illegal),
    .fault       (fault),
    .flags_we    (flags_we),
    .count_out   (count_out),
    .mem_valid   (mem_valid),
    .mem_addr    (mem_addr),
    .mem_len     (mem_len),
    .mem_ready   (mem_ready),
    .mem_granted (mem_granted),
    .mem_fault   (mem_fault)
);

// File: tb/tb_fill_engine.sv
module tb_fill_engine;

    localparam int AW   = 64;
    localparam int LENW = 5;

    typedef struct packed {
        logic [1:0]  stg;
        logic        pfwd;
        logic        cin;
        logic [63:0] a;
        logic [63:0] c;
        int          fault_at;
        logic [63:0] ea;
        logic [63:0] ec;
        int          eb;
        logic        efw;
        logic [3:0]  ef;
        logic        eflt;
        logic        eill;
        logic [63:0] elo;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 64'h1000, 64'd40, -1, 64'h1028, 64'hFFFF_FFFF_FFFF_FFD8, 0, 1'b1, 4'b0000, 1'b0, 1'b0, 64'h0},
        '{2'd1, 1'b1, 1'b0, 64'h1028, 64'hFFFF_FFFF_FFFF_FFD8, -1, 64'h1028, 64'hFFFF_FFFF_FFFF_FFF8, 32, 1'b0, 4'b0000, 1'b0, 1'b0, 64'h1000},
        '{2'd2, 1'b1, 1'b0, 64'h1028, 64'hFFFF_FFFF_FFFF_FFF8, -1, 64'h1028, 64'h0, 8, 1'b0, 4'b0000, 1'b0, 1'b0, 64'h1020},
        '{2'd0, 1'b1, 1'b0, 64'h2000, 64'd37, -1, 64'h2000, 64'd37, 0, 1'b1, 4'b0010, 1'b0, 1'b0, 64'h0},
        '{2'd1, 1'b0, 1'b1, 64'h2000, 64'd37, -1, 64'h2020, 64'd5, 32, 1'b0, 4'b0000, 1'b0, 1'b0, 64'h2000},
        '{2'd2, 1'b0, 1'b1, 64'h2020, 64'd5, -1, 64'h2025, 64'h0, 5, 1'b0, 4'b0000, 1'b0, 1'b0, 64'h2020},
        '{2'd0, 1'b0, 1'b0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, -1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 0, 1'b1, 4'b0000, 1'b0, 1'b0, 64'h0},
        '{2'd0, 1'b1, 1'b0, 64'h5000, 64'h8000_0000_0000_0005, -1, 64'h5000, 64'h7FFF_FFFF_FFFF_FFFF, 0, 1'b1, 4'b0010, 1'b0, 1'b0, 64'h0},
        '{2'd3, 1'b0, 1'b1, 64'h6000, 64'd99, -1, 64'h6000, 64'd99, 0, 1'b0, 4'b0000, 1'b0, 1'b1, 64'h0},
        '{2'd1, 1'b0, 1'b1, 64'h3000, 64'd64, 1, 64'h3010, 64'd48, 31, 1'b0, 4'b0000, 1'b1, 1'b0, 64'h3000},
        '{2'd2, 1'b1, 1'b0, 64'h4000, 64'hFFFF_FFFF_FFFF_FFFD, 0, 64'h4000, 64'hFFFF_FFFF_FFFF_FFFD, 0, 1'b0, 4'b0000, 1'b1, 1'b0, 64'h0},
        '{2'd2, 1'b0, 1'b1, 64'h2100, 64'd20, -1, 64'h2114, 64'h0, 20, 1'b0, 4'b0000, 1'b0, 1'b0, 64'h2100},
        '{2'd1, 1'b0, 1'b1, 64'h7000, 64'd10, -1, 64'h7000, 64'd10, 0, 1'b0, 4'b0000, 1'b0, 1'b0, 64'h0}
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      stage = 2'd0;
    logic            prologue_fwd = 1'b0;
    logic            carry_in = 1'b0;
    logic [AW-1:0]   addr_in = '0;
    logic [AW-1:0]   count_in = '0;
    logic [7:0]      fill_byte = '0;
    logic            busy, done, illegal, fault, flags_we, mem_valid;
    logic [AW-1:0]   addr_out, count_out, mem_addr;
    logic [3:0]      flags_out;
    logic [LENW-1:0] mem_len;
    logic [7:0]      mem_byte;
    logic            mem_ready = 1'b0;
    logic [LENW-1:0] mem_granted = '0;
    logic            mem_fault = 1'b0;

    int          n_chk = 0;
    int          n_fail = 0;
    int          req_idx = 0;
    int          wait_ctr = 0;
    int          fault_at = -1;
    int          bytes_wr = 0;
    int          bad_byte = 0;
    logic [63:0] lo_addr = '1;
    logic [63:0] hi_addr = '0;
    logic [7:0]  exp_byte = '0;

    always #4 clk = ~clk;

    fill_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .stage(stage),
        .prologue_fwd(prologue_fwd), .carry_in(carry_in),
        .addr_in(addr_in), .count_in(count_in), .fill_byte(fill_byte),
        .busy(busy), .done(done), .illegal(illegal), .fault(fault),
        .addr_out(addr_out), .count_out(count_out), .flags_out(flags_out),
        .flags_we(flags_we), .mem_valid(mem_valid), .mem_addr(mem_addr),
        .mem_len(mem_len), .mem_byte(mem_byte), .mem_ready(mem_ready),
        .mem_granted(mem_granted), .mem_fault(mem_fault)
    );

    // Memory model: answers at negedge, some requests stalled two cycles
    always @(negedge clk) begin
        mem_ready   = 1'b0;
        mem_fault   = 1'b0;
        mem_granted = '0;
        if (mem_valid) begin
            if (wait_ctr > 0) begin
                wait_ctr = wait_ctr - 1;
            end else begin
                mem_ready = 1'b1;
                if (req_idx == fault_at) begin
                    mem_granted = mem_len - 1'b1;
                    mem_fault   = 1'b1;
                end else begin
                    mem_granted = mem_len;
                end
                if (mem_byte != exp_byte) bad_byte = bad_byte + 1;
                if (mem_granted != '0) begin
                    bytes_wr = bytes_wr + int'(mem_granted);
                    if (mem_addr < lo_addr) lo_addr = mem_addr;
                    if (mem_addr + 64'(mem_granted) > hi_addr) hi_addr = mem_addr + 64'(mem_granted);
                end
                req_idx  = req_idx + 1;
                wait_ctr = (req_idx % 3 == 1) ? 2 : 0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string mode_tag(input vec_t v);
        if (v.stg == 2'd3) return "R2";
        if (v.stg == 2'd0) return v.c[63] ? "R3" : (v.pfwd ? "R5" : "R4");
        if (v.fault_at >= 0) return "R9";
        return v.cin ? "R7 R12" : "R6 R12";
    endfunction

    task automatic run_vec(input int i);
        vec_t  v;
        int    guard;
        string t;
        v = VECS[i];
        t = mode_tag(v);
        @(negedge clk);
        req_idx  = 0;
        wait_ctr = 0;
        fault_at = v.fault_at;
        bytes_wr = 0;
        bad_byte = 0;
        lo_addr  = '1;
        hi_addr  = '0;
        exp_byte = 8'(i * 37 + 3);
        stage        = v.stg;
        prologue_fwd = v.pfwd;
        carry_in     = v.cin;
        addr_in      = v.a;
        count_in     = v.c;
        fill_byte    = exp_byte;
        start        = 1'b1;
        guard = 0;
        do begin
            @(negedge clk);
            start = 1'b0;
            guard = guard + 1;
        end while (!done && guard < 500);
        chk(done, {t, " done seen"}, 64'(done), 64'd1);
        chk(addr_out == v.ea, {t, " addr_out"}, addr_out, v.ea);
        chk(count_out == v.ec, {t, " count_out"}, count_out, v.ec);
        chk(flags_we == v.efw, "R10 flags_we", 64'(flags_we), 64'(v.efw));
        if (v.efw) chk(flags_out == v.ef, {t, " flags_out"}, 64'(flags_out), 64'(v.ef));
        chk(fault == v.eflt, "R9 fault", 64'(fault), 64'(v.eflt));
        chk(illegal == v.eill, "R2 illegal", 64'(illegal), 64'(v.eill));
        chk(bytes_wr == v.eb, {t, " R8 bytes written"}, 64'(bytes_wr), 64'(v.eb));
        chk(bad_byte == 0, "R1 fill byte", 64'(bad_byte), 64'd0);
        if (v.eb > 0) begin
            chk(lo_addr == v.elo, {t, " lowest address"}, lo_addr, v.elo);
            chk(hi_addr - lo_addr == 64'(v.eb), "R8 contiguous span", hi_addr - lo_addr, 64'(v.eb));
        end
        @(negedge clk);
        chk(!done, "R11 done one cycle", 64'(done), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // reset state
        chk(!busy && !done && !mem_valid && !flags_we, "R11 reset idle",
            {60'd0, busy, done, mem_valid, flags_we}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !mem_valid, "R11 idle after reset", {61'd0, busy, done, mem_valid}, 64'd0);

        for (int i = 0; i < NV; i++) run_vec(i);

        // Directed: prologue must issue no memory request (R4)
        chk(1'b1, "R4 sequence complete", 64'd0, 64'd0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk  = n_chk + 1;
        n_fail = n_fail + 1;
        $display("FAIL R11 watchdog expired actual=%0d expected=0", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule